// File: doc/BRIEF.md
# I2C Command-Framed Register Target

This block is an I2C target for a small control port on a multi-channel converter. It watches open-drain SCL and SDA lines through synchronising flip-flops on the system clock. It acknowledges its own address, which is made of five fixed high bits and two strap pins. It turns the written byte stream into execute strobes. Each strobe lasts one clock and carries an 8-bit command and a 16-bit data word. The storage that acts on these strobes lives outside the block.

A normal write sends repeated three-byte groups: a command, then a data high byte, then a data low byte. A group is executed once its low byte has been acknowledged. If the first byte after the address equals a dedicated block code, the next byte is a starting register number. After that, two-byte data pairs follow, and they go to consecutive register indices. A read has four steps: a write of a command byte, a repeated START, a read address, and then two returned bytes. The two bytes come from a 16-bit readback input, which is indexed by the last command byte.

Top module: `i2c_cmd_target`

## Requirements
- R1: After reset, sda_pull_o and exec_o are low and rd_index_o is zero.
- R2: The address byte is sent MSB first. It is 0,0,0,1,1, then strap_i[1], then strap_i[0], then the R/W bit, where 0 means write. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: Once the address has matched, every byte the controller writes is acknowledged.
- R4: A group of command byte, data high byte and data low byte makes exec_o pulse for exactly one clock. The pulse comes after the ninth clock of the low byte. During the pulse, exec_cmd_o equals the command and exec_data_o equals {high, low}.
- R5: More groups may follow in the same transaction without a new START. Each one is executed, in the order it was sent.
- R6: Block mode starts when the command byte equals BLOCK_CODE (8'h5A by default). The next byte is a register number N. Each following pair of high byte and low byte makes one strobe. The k-th pair (counting from 0) has exec_cmd_o = N+k modulo 256.
- R7: A read has these steps: write address, command byte, repeated START, address with R/W=1. The target acknowledges the read address and sets rd_index_o to that command byte. It then sends rd_data_i[15:8] followed by rd_data_i[7:0], each MSB first, and produces no strobe.
- R8: After the controller NACKs the low read byte, SDA stays released until the next START or STOP.
- R9: A STOP or START before a group or pair is complete throws away the partial bytes and produces no strobe. Framing starts again at the address byte.
- R10: If the address does not match, the target never pulls SDA and produces no strobe until the next START.
- R11: sda_pull_o changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_pull_o | output | 1 | Pulls SDA low when high |
| strap_i | input | 2 | Low address bits taken from strap pins |
| exec_o | output | 1 | One-cycle execute strobe |
| exec_cmd_o | output | 8 | Command or register index for the strobe |
| exec_data_o | output | 16 | Data word for the strobe |
| rd_index_o | output | 8 | Last command byte, used to select the readback word |
| rd_data_i | input | 16 | Readback word returned on a read |

## Verification
The bench builds the block with its default parameters: two strap bits, high address bits 5'b00011, block code 8'h5A and two synchroniser stages. The vector walk drives the strap pins through all four values, so every variant of the address is matched. The block write starts at register FE, which pushes the index across its wrap from FF to 00. The readback input is tied to {index, ~index}, so the two returned bytes can be told apart in any bit position.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACKW, ST_ACKH, ST_TX, ST_TXACK, ST_TXLD, ST_SKIP
    } link_st_e;

    typedef enum logic [2:0] {
        PH_ADDR, PH_CMD, PH_HI, PH_LO, PH_BREG, PH_BHI, PH_BLO
    } frame_ph_e;

    typedef struct packed {
        link_st_e            st;
        frame_ph_e           ph;
        logic [3:0]          nbit;
        logic [BYTE_W-1:0]   sh;
        logic [BYTE_W-1:0]   cmd;
        logic [BYTE_W-1:0]   hi;
        logic [BYTE_W-1:0]   ridx;
        logic [WORD_W-1:0]   tx;
        logic                tx_lo;
        logic                rd;
        logic                pull;
        logic                exe;
        logic [BYTE_W-1:0]   ecmd;
        logic [WORD_W-1:0]   edat;
        logic [BYTE_W-1:0]   rsel;
    } link_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_sr_d, scl_sr_q, sda_sr_d, sda_sr_q;
    logic         scl_prev_d, scl_prev_q, sda_prev_d, sda_prev_q;

    always_comb begin
        scl_sr_d   = {scl_sr_q[MSB-1:0], scl_i};
        sda_sr_d   = {sda_sr_q[MSB-1:0], sda_i};
        scl_prev_d = scl_sr_q[MSB];
        sda_prev_d = sda_sr_q[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr_q   <= '1;
            sda_sr_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sr_q   <= scl_sr_d;
            sda_sr_q   <= sda_sr_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_lvl  = scl_sr_q[MSB];
    assign sda_lvl  = sda_sr_q[MSB];
    assign scl_rise = scl_lvl & ~scl_prev_q;
    assign scl_fall = ~scl_lvl & scl_prev_q;
    assign start_p  = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
    assign stop_p   = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import i2c_cmd_pkg::*;
#(
    parameter int                      STRAP_W    = 2,
    parameter logic [ADDR_W-STRAP_W-1:0] DEV_ID_HI = 5'b00011,
    parameter logic [BYTE_W-1:0]       BLOCK_CODE = 8'h5A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_p,
    input  logic               stop_p,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [WORD_W-1:0]  rd_data_i,
    output logic               sda_pull_o,
    output logic               exec_o,
    output logic [BYTE_W-1:0]  exec_cmd_o,
    output logic [WORD_W-1:0]  exec_data_o,
    output logic [BYTE_W-1:0]  rd_index_o
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
    localparam logic [3:0] FULL     = 4'(BYTE_W);

    link_t q, n;

    always_comb begin
        n     = q;
        n.exe = 1'b0;
        if (start_p) begin
            n.st    = ST_RX;
            n.ph    = PH_ADDR;
            n.nbit  = '0;
            n.pull  = 1'b0;
            n.tx_lo = 1'b0;
        end else if (stop_p) begin
            n.st   = ST_IDLE;
            n.pull = 1'b0;
        end else begin
            case (q.st)
                ST_RX: if (scl_rise) begin
                    n.sh   = {q.sh[BYTE_W-2:0], sda_lvl};
                    n.nbit = q.nbit + 4'd1;
                    if (q.nbit == LAST_BIT) begin
                        if (q.ph == PH_ADDR &&
                            n.sh[BYTE_W-1:1] != {DEV_ID_HI, strap_i}) begin
                            n.st = ST_SKIP;
                        end else begin
                            n.st = ST_ACKW;
                            if (q.ph == PH_ADDR) n.rd = n.sh[0];
                        end
                    end
                end
                ST_ACKW: if (scl_fall) begin
                    n.pull = 1'b1;
                    n.st   = ST_ACKH;
                end
                ST_ACKH: if (scl_fall) begin
                    n.pull = 1'b0;
                    n.nbit = '0;
                    n.st   = ST_RX;
                    case (q.ph)
                        PH_ADDR: begin
                            if (q.rd) begin
                                n.st    = ST_TX;
                                n.tx    = {rd_data_i[WORD_W-2:0], 1'b0};
                                n.pull  = ~rd_data_i[WORD_W-1];
                                n.nbit  = 4'd1;
                                n.tx_lo = 1'b0;
                            end else begin
                                n.ph = PH_CMD;
                            end
                        end
                        PH_CMD: begin
                            n.cmd  = q.sh;
                            n.rsel = q.sh;
                            n.ph   = (q.sh == BLOCK_CODE) ? PH_BREG : PH_HI;
                        end
                        PH_HI: begin
                            n.hi = q.sh;
                            n.ph = PH_LO;
                        end
                        PH_LO: begin
                            n.exe  = 1'b1;
                            n.ecmd = q.cmd;
                            n.edat = {q.hi, q.sh};
                            n.ph   = PH_CMD;
                        end
                        PH_BREG: begin
                            n.ridx = q.sh;
                            n.ph   = PH_BHI;
                        end
                        PH_BHI: begin
                            n.hi = q.sh;
                            n.ph = PH_BLO;
                        end
                        PH_BLO: begin
                            n.exe  = 1'b1;
                            n.ecmd = q.ridx;
                            n.edat = {q.hi, q.sh};
                            n.ridx = q.ridx + 8'd1;
                            n.ph   = PH_BHI;
                        end
                        default: n.st = ST_SKIP;
                    endcase
                end
                ST_TX: if (scl_fall) begin
                    if (q.nbit == FULL) begin
                        n.pull = 1'b0;
                        n.st   = ST_TXACK;
                    end else begin
                        n.pull = ~q.tx[WORD_W-1];
                        n.tx   = {q.tx[WORD_W-2:0], 1'b0};
                        n.nbit = q.nbit + 4'd1;
                    end
                end
                ST_TXACK: if (scl_rise) begin
                    if (!sda_lvl && !q.tx_lo) begin
                        n.tx_lo = 1'b1;
                        n.st    = ST_TXLD;
                    end else begin
                        n.st = ST_SKIP;
                    end
                end
                ST_TXLD: if (scl_fall) begin
                    n.pull = ~q.tx[WORD_W-1];
                    n.tx   = {q.tx[WORD_W-2:0], 1'b0};
                    n.nbit = 4'd1;
                    n.st   = ST_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ph: PH_ADDR, default: '0};
        end else begin
            q <= n;
        end
    end

    assign sda_pull_o  = q.pull;
    assign exec_o      = q.exe;
    assign exec_cmd_o  = q.ecmd;
    assign exec_data_o = q.edat;
    assign rd_index_o  = q.rsel;
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
    import i2c_cmd_pkg::*;
#(
    parameter int                        STRAP_W     = 2,
    parameter logic [ADDR_W-STRAP_W-1:0] DEV_ID_HI   = 5'b00011,
    parameter logic [BYTE_W-1:0]         BLOCK_CODE  = 8'h5A,
    parameter int                        SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               exec_o,
    output logic [BYTE_W-1:0]  exec_cmd_o,
    output logic [WORD_W-1:0]  exec_data_o,
    output logic [BYTE_W-1:0]  rd_index_o,
    input  logic [WORD_W-1:0]  rd_data_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_s),
        .sda_lvl  (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    i2c_link_fsm #(
        .STRAP_W    (STRAP_W),
        .DEV_ID_HI  (DEV_ID_HI),
        .BLOCK_CODE (BLOCK_CODE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_lvl     (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_p     (start_p),
        .stop_p      (stop_p),
        .strap_i     (strap_i),
        .rd_data_i   (rd_data_i),
        .sda_pull_o  (sda_pull_o),
        .exec_o      (exec_o),
        .exec_cmd_o  (exec_cmd_o),
        .exec_data_o (exec_data_o),
        .rd_index_o  (rd_index_o)
    );
endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_lvl,
    input logic start_p,
    input logic stop_p,
    input logic sda_pull_o,
    input logic exec_o
);
    assert_exec_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |=> !exec_o);

    assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_lvl);

    assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !sda_pull_o);

    assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !sda_pull_o);

    assert_no_exec_on_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p || stop_p) |=> !exec_o);
endmodule

bind i2c_cmd_target i2c_cmd_target_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (scl_s),
    .start_p    (start_p),
    .stop_p     (stop_p),
    .sda_pull_o (sda_pull_o),
    .exec_o     (exec_o)
);

// File: tb/i2c_cmd_target_tb.sv
module i2c_cmd_target_tb;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'd0;
    logic        sda_pull, exec_v;
    logic [7:0]  exec_cmd, rd_index;
    logic [15:0] exec_data, rd_data;
    logic        sda_line;

    int n_chk = 0, n_fail = 0, ex_n = 0;
    logic [7:0]  ex_cmd [32];
    logic [15:0] ex_dat [32];
    bit pull_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign rd_data  = {rd_index, ~rd_index};

    i2c_cmd_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .strap_i(strap), .exec_o(exec_v),
        .exec_cmd_o(exec_cmd), .exec_data_o(exec_data),
        .rd_index_o(rd_index), .rd_data_i(rd_data)
    );

    always @(negedge clk) begin
        if (rst_n && exec_v && ex_n < 32) begin
            ex_cmd[ex_n] = exec_cmd;
            ex_dat[ex_n] = exec_data;
            ex_n++;
        end
        if (sda_pull) pull_seen = 1;
    end

    // strap, cmd, data
    localparam logic [25:0] VEC [6] = '{
        {2'd0, 8'h01, 16'h0ABC}, {2'd1, 8'h12, 16'hFFFF},
        {2'd2, 8'h23, 16'h0000}, {2'd3, 8'hFE, 16'h8001},
        {2'd0, 8'h00, 16'h5555}, {2'd3, 8'h7F, 16'hAAAA}};

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
    endtask

    task automatic put(input logic [7:0] b, input bit exp_ack, input string rq);
        bit acked;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
        end
        sda_m = 1; wq(); scl_m = 1; wq();
        acked = !sda_line;
        wq(); scl_m = 0; wq();
        check(acked == exp_ack, rq, 32'(acked), 32'(exp_ack));
    endtask

    task automatic get(input bit give_ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1; wq(); b[i] = sda_line; wq(); scl_m = 0;
        end
        sda_m = ~give_ack; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
        sda_m = 1;
    endtask

    function automatic logic [7:0] adr(input logic [1:0] s, input bit r);
        return {5'b00011, s, r};
    endfunction

    initial begin
        int base;
        logic [7:0] hb, lb;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sda_pull == 0, "R1 sda_pull", 32'(sda_pull), 0);
        check(exec_v == 0, "R1 exec", 32'(exec_v), 0);
        check(rd_index == 0, "R1 rd_index", 32'(rd_index), 0);
        rst_n = 1; wq();

        // R2 R3 R4: table walk
        for (int v = 0; v < 6; v++) begin
            strap = VEC[v][25:24];
            base = ex_n;
            bus_start();
            put(adr(VEC[v][25:24], 0), 1, "R2 address ack");
            put(VEC[v][23:16], 1, "R3 cmd ack");
            put(VEC[v][15:8], 1, "R3 hi ack");
            put(VEC[v][7:0], 1, "R3 lo ack");
            check(ex_n == base + 1, "R4 strobe count", 32'(ex_n), 32'(base + 1));
            check(ex_cmd[base] == VEC[v][23:16], "R4 cmd", 32'(ex_cmd[base]), 32'(VEC[v][23:16]));
            check(ex_dat[base] == VEC[v][15:0], "R4 data", 32'(ex_dat[base]), 32'(VEC[v][15:0]));
            bus_stop();
        end

        // R5 several triplets in one transaction
        strap = 2'd2; base = ex_n;
        bus_start();
        put(adr(2'd2, 0), 1, "R2");
        put(8'h31, 1, "R5"); put(8'h11, 1, "R5"); put(8'h22, 1, "R5");
        put(8'h32, 1, "R5"); put(8'h33, 1, "R5"); put(8'h44, 1, "R5");
        put(8'h35, 1, "R5"); put(8'h55, 1, "R5"); put(8'h66, 1, "R5");
        bus_stop();
        check(ex_n == base + 3, "R5 count", 32'(ex_n), 32'(base + 3));
        check({ex_cmd[base], ex_dat[base]} == 24'h311122, "R5 first", {ex_cmd[base], ex_dat[base]}, 24'h311122);
        check({ex_cmd[base+1], ex_dat[base+1]} == 24'h323344, "R5 second", {ex_cmd[base+1], ex_dat[base+1]}, 24'h323344);
        check({ex_cmd[base+2], ex_dat[base+2]} == 24'h355566, "R5 third", {ex_cmd[base+2], ex_dat[base+2]}, 24'h355566);

        // R6 block mode starting at FE, wraps to 00
        base = ex_n;
        bus_start();
        put(adr(2'd2, 0), 1, "R2");
        put(8'h5A, 1, "R6"); put(8'hFE, 1, "R6");
        put(8'hA1, 1, "R6"); put(8'hB2, 1, "R6");
        put(8'hC3, 1, "R6"); put(8'hD4, 1, "R6");
        put(8'hE5, 1, "R6"); put(8'hF6, 1, "R6");
        bus_stop();
        check(ex_n == base + 3, "R6 count", 32'(ex_n), 32'(base + 3));
        check({ex_cmd[base], ex_dat[base]} == 24'hFEA1B2, "R6 pair0", {ex_cmd[base], ex_dat[base]}, 24'hFEA1B2);
        check({ex_cmd[base+1], ex_dat[base+1]} == 24'hFFC3D4, "R6 pair1", {ex_cmd[base+1], ex_dat[base+1]}, 24'hFFC3D4);
        check({ex_cmd[base+2], ex_dat[base+2]} == 24'h00E5F6, "R6 pair2 wrap", {ex_cmd[base+2], ex_dat[base+2]}, 24'h00E5F6);

        // R7 R8 read
        base = ex_n;
        bus_start();
        put(adr(2'd2, 0), 1, "R7 write addr");
        put(8'h3C, 1, "R7 cmd");
        bus_start();
        put(adr(2'd2, 1), 1, "R7 read addr ack");
        check(rd_index == 8'h3C, "R7 rd_index", 32'(rd_index), 32'h3C);
        get(1, hb);
        get(0, lb);
        check(hb == 8'h3C, "R7 high byte", 32'(hb), 32'h3C);
        check(lb == 8'hC3, "R7 low byte", 32'(lb), 32'hC3);
        pull_seen = 0; wq(); wq(); wq();
        check(pull_seen == 0, "R8 released after NACK", 32'(pull_seen), 0);
        bus_stop();
        check(sda_pull == 0, "R8 released after STOP", 32'(sda_pull), 0);
        check(ex_n == base, "R7 no strobe", 32'(ex_n), 32'(base));

        // R9 stop inside a triplet
        base = ex_n;
        bus_start();
        put(adr(2'd2, 0), 1, "R9"); put(8'h40, 1, "R9"); put(8'h41, 1, "R9");
        bus_stop();
        check(ex_n == base, "R9 stop discards", 32'(ex_n), 32'(base));
        // R9 repeated start inside a triplet
        bus_start();
        put(adr(2'd2, 0), 1, "R9"); put(8'h44, 1, "R9"); put(8'h11, 1, "R9"); put(8'h22, 1, "R9");
        put(8'h45, 1, "R9"); put(8'h33, 1, "R9");
        bus_start();
        put(adr(2'd2, 0), 1, "R9"); put(8'h46, 1, "R9"); put(8'h01, 1, "R9"); put(8'h02, 1, "R9");
        bus_stop();
        check(ex_n == base + 2, "R9 start discards", 32'(ex_n), 32'(base + 2));
        check({ex_cmd[base], ex_dat[base]} == 24'h441122, "R9 before", {ex_cmd[base], ex_dat[base]}, 24'h441122);
        check({ex_cmd[base+1], ex_dat[base+1]} == 24'h460102, "R9 after", {ex_cmd[base+1], ex_dat[base+1]}, 24'h460102);
        // R9 partial block pair
        base = ex_n;
        bus_start();
        put(adr(2'd2, 0), 1, "R9"); put(8'h5A, 1, "R9"); put(8'h10, 1, "R9"); put(8'hAA, 1, "R9");
        bus_stop();
        check(ex_n == base, "R9 partial pair", 32'(ex_n), 32'(base));

        // R10 address mismatch
        strap = 2'd1; base = ex_n; pull_seen = 0;
        bus_start();
        put(adr(2'd2, 0), 0, "R10 no ack");
        put(8'h50, 0, "R10"); put(8'h51, 0, "R10"); put(8'h52, 0, "R10");
        bus_stop();
        check(pull_seen == 0, "R10 SDA released", 32'(pull_seen), 0);
        check(ex_n == base, "R10 no strobe", 32'(ex_n), 32'(base));
        bus_start();
        put({5'b01011, 2'd1, 1'b0}, 0, "R10 high bits differ");
        bus_stop();
        bus_start();
        put(adr(2'd1, 0), 1, "R10 next START"); put(8'h60, 1, "R10"); put(8'h61, 1, "R10"); put(8'h62, 1, "R10");
        bus_stop();
        check(ex_n == base + 1 && ex_dat[base] == 16'h6162, "R10 recovery", 32'(ex_dat[base]), 32'h6162);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all R) actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule